// File: doc/BRIEF.md
# SMBus Slave Message Decoder

This block sits behind a bit-level SMBus slave shifter and works at byte level. The shifter reports start, stop and received bytes. The decoder compares each address byte with a 7-bit programmable slave address. It then classifies the transaction as a Byte Write, a Byte Read or a Host Notify. For every byte it returns an ACK or NACK decision. Written data is stored in a small receive-data array. On a read, the decoder supplies one state byte chosen by the command code. It raises sticky status flags that a local processor can poll and clear. The block has no PEC byte handling and no physical-layer logic.

The message kind is decided by the number of bytes and the framing that follow the address(W) byte:
- A command byte followed by a repeated start and a matching address(R) is a Byte Read.
- Exactly two bytes followed by a stop form a Byte Write.
- Exactly three bytes form a Host Notify: device address, data low, data high.

A watchdog counter aborts a transaction that stalls with both bus lines high.

The received-byte input is a valid/ready stream. `rx_ready` is permanently high, so a byte is consumed in the cycle its `rx_valid` is seen.

The read-data output is also a valid/ready stream. Once `rd_valid` rises, `rd_valid` and `rd_data` hold until `rd_ready` is seen. The offer is withdrawn if a start, a stop or a timeout comes first.

All other pins are plain level or pulse signals.

Top module: `smb_slave_decoder`

## Requirements
- R1: The slave address reads 0x44 after reset. A cycle with `cfg_we` high loads `cfg_addr` into it, and it changes at no other time.
- R2: The first byte after a start or repeated start is the address byte. Bits [7:1] are compared with the slave address, and bit 0 is 1 for read. A matching write address is ACKed. A matching read address is ACKed only when a one-byte write phase came just before it. Every other address byte is NACKed.
- R3: Byte Write is address(W), command C, data D, then stop. On the stop, D is stored in `recv_data[C*8 +: 8]` if C < NUM_DATA, and the SMI status flag is set.
- R4: Byte Read is address(W), command C, repeated start, address(R). After the read address is ACKed, `rd_valid` rises one cycle later. `rd_data` carries state byte C from `state_bytes[C*8 +: 8]`, or 0x00 when C >= NUM_STATE. The SMI flag is set. The offer holds until `rd_ready`, start, stop or timeout.
- R5: Host Notify is address(W) followed by three bytes. These are latched into `notify_dev`, `notify_lo` and `notify_hi`, and the notify flag is set while the SMI flag is left alone. Any byte beyond the third is NACKed, because no PEC byte exists.
- R6: After a NACKed address byte, every byte is NACKed and has no effect until the next start or stop.
- R7: While a transaction is open, a run of TMO_CYC cycles with `line_high` set and no bus edge, start, stop or byte returns the decoder to idle. After that the next byte is NACKed and a pending read offer is withdrawn. A bus edge restarts the count.
- R8: `sts_clr[0]` clears the notify flag and `sts_clr[1]` clears the SMI flag. When a set and a clear land in the same cycle, the set wins.
- R9: Each byte accepted on `rx_valid` produces exactly one `ack_valid` pulse on the next cycle, with `ack_ok` high for ACK and low for NACK. `rx_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Slave-address write strobe |
| cfg_addr | input | 7 | New slave address |
| slv_addr | output | 7 | Current slave address |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| bus_edge | input | 1 | Any SCL/SDA edge seen |
| line_high | input | 1 | SCL and SDA both high |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always high |
| ack_valid | output | 1 | ACK decision strobe |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid | output | 1 | Read byte offered |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Shifter took the read byte |
| state_bytes | input | 8*NUM_STATE | Readable state bytes |
| sts_clr | input | 2 | Write-one-to-clear for the status flags |
| sts_notify | output | 1 | Host Notify received |
| sts_smi | output | 1 | Other matching message received |
| recv_data | output | 8*NUM_DATA | Receive data array |
| notify_dev | output | 8 | Host Notify device address |
| notify_lo | output | 8 | Host Notify data low |
| notify_hi | output | 8 | Host Notify data high |

## Verification
The commit of a finished message and a processor clear of the same status flag can meet in one cycle. The bench provokes this by pulsing the SMI clear exactly on the cycle after the stop edge, which is when the Byte Write commit updates the flag. It then checks that the flag stays set and that the data byte was stored. A second pair, a pending read offer and a watchdog abort, is provoked by holding `line_high` with the offer unaccepted; the bench expects `rd_valid` to fall.

// File: rtl/smbd_pkg.sv
package smbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_IGN
  } smbd_state_e;

  localparam logic [6:0] SMBD_ADDR_RST = 7'h44;
endpackage

// File: rtl/smbd_timeout.sv
module smbd_timeout #(
  parameter int TMO_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic line_high,
  input  logic activity,
  output logic tmo
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;
  logic          en;

  assign en = busy && line_high && !activity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        cnt <= '0;
        tmo <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbd_msg_fsm.sv
module smbd_msg_fsm
  import smbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       tmo_i,
  input  logic       byte_v,
  input  logic [7:0] byte_i,
  input  logic [6:0] own_addr,
  output logic       ack_v,
  output logic       ack_ok,
  output logic       wr_commit,
  output logic       hn_commit,
  output logic       rd_req,
  output logic       busy,
  output logic [7:0] b1_o,
  output logic [7:0] b2_o,
  output logic [7:0] b3_o
);
  smbd_state_e st;
  logic [1:0]  cnt;
  logic        rd_pend;
  logic        hit;

  assign hit  = (byte_i[7:1] == own_addr);
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rd_pend   <= 1'b0;
      ack_v     <= 1'b0;
      ack_ok    <= 1'b0;
      wr_commit <= 1'b0;
      hn_commit <= 1'b0;
      rd_req    <= 1'b0;
      b1_o      <= '0;
      b2_o      <= '0;
      b3_o      <= '0;
    end else begin
      ack_v     <= 1'b0;
      ack_ok    <= 1'b0;
      wr_commit <= 1'b0;
      hn_commit <= 1'b0;
      rd_req    <= 1'b0;
      if (tmo_i) begin
        st      <= ST_IDLE;
        rd_pend <= 1'b0;
      end else if (stop_i) begin
        wr_commit <= (st == ST_WR) && (cnt == 2'd2);
        st        <= ST_IDLE;
        rd_pend   <= 1'b0;
      end else if (start_i) begin
        rd_pend <= (st == ST_WR) && (cnt == 2'd1);
        st      <= ST_ADDR;
      end else if (byte_v) begin
        ack_v <= 1'b1;
        case (st)
          ST_ADDR: begin
            rd_pend <= 1'b0;
            if (hit && !byte_i[0]) begin
              st     <= ST_WR;
              cnt    <= '0;
              ack_ok <= 1'b1;
            end else if (hit && rd_pend) begin
              st     <= ST_RD;
              rd_req <= 1'b1;
              ack_ok <= 1'b1;
            end else begin
              st <= ST_IGN;
            end
          end
          ST_WR: begin
            case (cnt)
              2'd0: begin b1_o <= byte_i; cnt <= 2'd1; ack_ok <= 1'b1; end
              2'd1: begin b2_o <= byte_i; cnt <= 2'd2; ack_ok <= 1'b1; end
              2'd2: begin
                b3_o      <= byte_i;
                cnt       <= 2'd3;
                ack_ok    <= 1'b1;
                hn_commit <= 1'b1;
              end
              default: st <= ST_IGN;
            endcase
          end
          default: ack_ok <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbd_regs.sv
module smbd_regs
  import smbd_pkg::*;
#(
  parameter int NUM_DATA  = 4,
  parameter int NUM_STATE = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [6:0]             cfg_addr,
  input  logic                   wr_commit,
  input  logic                   hn_commit,
  input  logic                   rd_req,
  input  logic                   rd_ready,
  input  logic                   abort,
  input  logic [7:0]             b1,
  input  logic [7:0]             b2,
  input  logic [7:0]             b3,
  input  logic [8*NUM_STATE-1:0] state_bytes,
  input  logic [1:0]             sts_clr,
  output logic [6:0]             own_addr,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  output logic [8*NUM_DATA-1:0]  recv_data,
  output logic [7:0]             notify_dev,
  output logic [7:0]             notify_lo,
  output logic [7:0]             notify_hi,
  output logic                   sts_notify,
  output logic                   sts_smi
);
  logic [7:0] sel_byte;

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < NUM_STATE; i++) begin
      if (b1 == 8'(i)) sel_byte = state_bytes[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr   <= SMBD_ADDR_RST;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      notify_dev <= '0;
      notify_lo  <= '0;
      notify_hi  <= '0;
      sts_notify <= 1'b0;
      sts_smi    <= 1'b0;
    end else begin
      if (cfg_we) own_addr <= cfg_addr;
      if (abort) begin
        rd_valid <= 1'b0;
      end else if (rd_req) begin
        rd_valid <= 1'b1;
        rd_data  <= sel_byte;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
      if (hn_commit) begin
        notify_dev <= b1;
        notify_lo  <= b2;
        notify_hi  <= b3;
      end
      sts_notify <= (sts_notify & ~sts_clr[0]) | hn_commit;
      sts_smi    <= (sts_smi & ~sts_clr[1]) | wr_commit | rd_req;
    end
  end

  for (genvar g = 0; g < NUM_DATA; g++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        recv_data[g*8 +: 8] <= '0;
      end else if (wr_commit && (b1 == 8'(g))) begin
        recv_data[g*8 +: 8] <= b2;
      end
    end
  end
endmodule

// File: rtl/smb_slave_decoder.sv
module smb_slave_decoder #(
  parameter int NUM_DATA  = 4,
  parameter int NUM_STATE = 4,
  parameter int TMO_CYC   = 6250
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [6:0]             cfg_addr,
  output logic [6:0]             slv_addr,
  input  logic                   bus_start,
  input  logic                   bus_stop,
  input  logic                   bus_edge,
  input  logic                   line_high,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   rx_ready,
  output logic                   ack_valid,
  output logic                   ack_ok,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  input  logic                   rd_ready,
  input  logic [8*NUM_STATE-1:0] state_bytes,
  input  logic [1:0]             sts_clr,
  output logic                   sts_notify,
  output logic                   sts_smi,
  output logic [8*NUM_DATA-1:0]  recv_data,
  output logic [7:0]             notify_dev,
  output logic [7:0]             notify_lo,
  output logic [7:0]             notify_hi
);
  logic       tmo, busy, wr_commit, hn_commit, rd_req, activity;
  logic [7:0] b1, b2, b3;

  assign rx_ready = 1'b1;
  assign activity = bus_edge | bus_start | bus_stop | rx_valid;

  smbd_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .busy(busy), .line_high(line_high),
    .activity(activity), .tmo(tmo)
  );

  smbd_msg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(bus_start), .stop_i(bus_stop),
    .tmo_i(tmo), .byte_v(rx_valid), .byte_i(rx_data), .own_addr(slv_addr),
    .ack_v(ack_valid), .ack_ok(ack_ok), .wr_commit(wr_commit),
    .hn_commit(hn_commit), .rd_req(rd_req), .busy(busy),
    .b1_o(b1), .b2_o(b2), .b3_o(b3)
  );

  smbd_regs #(.NUM_DATA(NUM_DATA), .NUM_STATE(NUM_STATE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .wr_commit(wr_commit), .hn_commit(hn_commit), .rd_req(rd_req),
    .rd_ready(rd_ready), .abort(bus_start | bus_stop | tmo),
    .b1(b1), .b2(b2), .b3(b3), .state_bytes(state_bytes), .sts_clr(sts_clr),
    .own_addr(slv_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .recv_data(recv_data), .notify_dev(notify_dev), .notify_lo(notify_lo),
    .notify_hi(notify_hi), .sts_notify(sts_notify), .sts_smi(sts_smi)
  );
endmodule

// File: rtl/smbd_checker.sv
module smbd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       ack_valid,
  input logic       ack_ok,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       tmo,
  input logic       cfg_we,
  input logic [6:0] slv_addr,
  input logic       sts_notify,
  input logic       sts_smi,
  input logic [1:0] sts_clr
);
  assert_ack_follows_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid));

  assert_addr_only_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slv_addr) |-> $past(cfg_we));

  assert_read_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(ack_valid && ack_ok));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !bus_start && !bus_stop && !tmo) |=> (rd_valid && $stable(rd_data)));

  assert_notify_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_notify) |-> $past(ack_valid && ack_ok));

  assert_smi_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_smi) |-> $past(sts_clr[1]));
endmodule

bind smb_slave_decoder smbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ack_valid(ack_valid),
  .ack_ok(ack_ok), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .bus_start(bus_start), .bus_stop(bus_stop), .tmo(tmo), .cfg_we(cfg_we),
  .slv_addr(slv_addr), .sts_notify(sts_notify), .sts_smi(sts_smi),
  .sts_clr(sts_clr)
);

// File: tb/sim_smb_slave_decoder.sv
`timescale 1ns/1ps
module sim_smb_slave_decoder;
  localparam int ND = 4, NS = 4, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, bus_start = 0, bus_stop = 0, bus_edge = 0, line_high = 0;
  logic rx_valid = 0, rd_ready = 0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] rx_data = '0;
  logic [1:0] sts_clr = '0;
  logic [8*NS-1:0] state_bytes;
  logic [6:0] slv_addr;
  logic rx_ready, ack_valid, ack_ok, rd_valid, sts_notify, sts_smi;
  logic [7:0] rd_data, notify_dev, notify_lo, notify_hi;
  logic [8*ND-1:0] recv_data, model;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  smb_slave_decoder #(.NUM_DATA(ND), .NUM_STATE(NS), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .slv_addr(slv_addr), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_edge(bus_edge), .line_high(line_high), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .state_bytes(state_bytes), .sts_clr(sts_clr),
    .sts_notify(sts_notify), .sts_smi(sts_smi), .recv_data(recv_data),
    .notify_dev(notify_dev), .notify_lo(notify_lo), .notify_hi(notify_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start();
    bus_start = 1; tick(); bus_start = 0;
  endtask

  task automatic do_stop();
    bus_stop = 1; tick(); bus_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    rx_valid = 1; rx_data = b; tick(); rx_valid = 0;
    chk("R9 ack strobe", {31'd0, ack_valid}, 32'd1);
    a = ack_ok;
  endtask

  task automatic clear_all();
    sts_clr = 2'b11; tick(); sts_clr = 2'b00;
  endtask

  function automatic logic [7:0] sbyte(input int i);
    return 8'(8'hA0 + i * 7);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic a;
    for (int i = 0; i < NS; i++) state_bytes[i*8 +: 8] = sbyte(i);
    model = '0;
    repeat (4) tick();
    rst_n = 1; tick();

    // reset state
    chk("R1 reset address", {25'd0, slv_addr}, 32'h44);
    chk("R9 rx_ready", {31'd0, rx_ready}, 32'd1);
    chk("R4 rd_valid reset", {31'd0, rd_valid}, 0);
    chk("R8 status reset", {30'd0, sts_notify, sts_smi}, 0);
    chk("R3 recv reset", recv_data, 0);

    // R2: address sweep with default address
    for (int ad = 0; ad < 128; ad++) begin
      do_start();
      send({7'(ad), 1'b0}, a);
      chk("R2 address match", {31'd0, a}, (ad == 'h44) ? 1 : 0);
      do_stop(); tick();
    end
    do_start(); send(8'h89, a);
    chk("R2 read without command", {31'd0, a}, 0);
    do_stop(); tick();

    // R6: ignore after NACK
    do_start(); send(8'h44, a);
    chk("R6 nack address", {31'd0, a}, 0);
    send(8'h00, a); chk("R6 ignored byte", {31'd0, a}, 0);
    send(8'h09, a); chk("R6 ignored byte", {31'd0, a}, 0);
    do_stop(); tick(); tick();
    chk("R6 no store", recv_data, 0);
    chk("R6 no status", {31'd0, sts_smi}, 0);

    // R1: program new address
    cfg_we = 1; cfg_addr = 7'h13; tick(); cfg_we = 0;
    chk("R1 programmed address", {25'd0, slv_addr}, 32'h13);
    do_start(); send(8'h88, a);
    chk("R1 old address refused", {31'd0, a}, 0);
    do_stop(); tick();

    // R3: byte write sweep
    for (int c = 0; c < ND + 2; c++) begin
      logic [7:0] d;
      d = 8'(c * 37 + 5);
      do_start();
      send(8'h26, a); chk("R3 addr ack", {31'd0, a}, 1);
      send(8'(c), a); chk("R3 cmd ack", {31'd0, a}, 1);
      send(d, a);     chk("R3 data ack", {31'd0, a}, 1);
      do_stop(); tick();
      if (c < ND) model[c*8 +: 8] = d;
      chk("R3 stored data", recv_data, model);
      chk("R3 smi set", {31'd0, sts_smi}, 1);
      chk("R3 notify untouched", {31'd0, sts_notify}, 0);
      sts_clr = 2'b10; tick(); sts_clr = 2'b00;
      chk("R8 smi cleared", {31'd0, sts_smi}, 0);
    end

    // R8: set and clear in the same cycle
    do_start(); send(8'h26, a); send(8'h01, a); send(8'h55, a);
    do_stop();
    sts_clr = 2'b10; tick(); sts_clr = 2'b00;
    model[8 +: 8] = 8'h55;
    chk("R8 set wins over clear", {31'd0, sts_smi}, 1);
    chk("R3 collision data", recv_data, model);
    clear_all();

    // R4: byte read sweep
    for (int c = 0; c < NS + 2; c++) begin
      do_start(); send(8'h26, a); send(8'(c), a);
      do_start(); send(8'h27, a);
      chk("R4 read addr ack", {31'd0, a}, 1);
      tick();
      chk("R4 rd_valid", {31'd0, rd_valid}, 1);
      chk("R4 rd_data", {24'd0, rd_data}, (c < NS) ? {24'd0, sbyte(c)} : 0);
      tick();
      chk("R4 offer held", {31'd0, rd_valid}, 1);
      rd_ready = 1; tick(); rd_ready = 0;
      chk("R4 offer taken", {31'd0, rd_valid}, 0);
      do_stop(); tick();
      chk("R4 smi set", {31'd0, sts_smi}, 1);
      clear_all();
    end

    // R5: host notify, fourth byte refused
    do_start();
    send(8'h26, a); send(8'h3C, a); send(8'h11, a); send(8'h22, a);
    chk("R5 third byte ack", {31'd0, a}, 1);
    send(8'h33, a);
    chk("R5 extra byte nack", {31'd0, a}, 0);
    do_stop(); tick();
    chk("R5 notify regs", {8'd0, notify_dev, notify_lo, notify_hi}, 32'h3C1122);
    chk("R5 notify flag", {31'd0, sts_notify}, 1);
    chk("R5 smi untouched", {31'd0, sts_smi}, 0);
    chk("R5 recv untouched", recv_data, model);
    clear_all();
    chk("R8 notify cleared", {31'd0, sts_notify}, 0);

    // R7: timeout aborts
    do_start(); send(8'h26, a);
    line_high = 1; repeat (TMO + 2) tick(); line_high = 0;
    send(8'h01, a);
    chk("R7 aborted to idle", {31'd0, a}, 0);
    do_stop(); tick();

    // R7: bus edges keep the transaction alive
    do_start(); send(8'h26, a);
    line_high = 1;
    for (int k = 0; k < 4; k++) begin
      repeat (TMO - 4) tick();
      bus_edge = 1; tick(); bus_edge = 0;
    end
    line_high = 0;
    send(8'h02, a); chk("R7 alive cmd", {31'd0, a}, 1);
    send(8'h77, a); chk("R7 alive data", {31'd0, a}, 1);
    do_stop(); tick();
    model[16 +: 8] = 8'h77;
    chk("R7 alive store", recv_data, model);
    clear_all();

    // R7: timeout withdraws a pending read offer
    do_start(); send(8'h26, a); send(8'h00, a);
    do_start(); send(8'h27, a); tick();
    chk("R4 offer before timeout", {31'd0, rd_valid}, 1);
    line_high = 1; repeat (TMO + 2) tick(); line_high = 0;
    chk("R7 offer withdrawn", {31'd0, rd_valid}, 0);
    do_stop(); tick();

    finish_run();
  end
endmodule